// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block runs single management-frame transactions (Clause 22 style) between a host and an Ethernet PHY. Software writes a command word into a small register file: the PHY address, the PHY register number, and a read/write selector. For a write it also loads a 16-bit data word. It then sets a go/busy bit in the control register. The block serializes the frame onto the management data line and times it with a management clock (MDC), which it divides down from the system clock.

The go bit reads as 1 for the whole transaction, and hardware clears it when the frame is finished. On a read, the line is released from the turnaround onward. The 16 bits returned by the PHY are captured and held in a read-data register. Software fetches them after the go bit has dropped. The control register also has an enable bit that reads back exactly as written, so software can detect that the management function is present. No transaction can start while this bit is 0.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Registers are decoded at byte offsets 0x7E4 (command: bits 10:0 read back as written, upper bits read 0), 0x7E8 (write data: bits 15:0 read back), 0x7EC (read data, bits 15:0, read only) and 0x7F0 (control: bit 3 enable reads back as written, bit 0 go/busy). Any other offset reads 0.
- R2: Command bit fields are as follows: bits 4:0 are the PHY register number, bits 9:5 are the PHY address, and bit 10 is 1 for a read and 0 for a write. The frame carries the address before the register number, and each field is sent MSB first.
- R3: A write frame is 64 bits long and is driven with the output enable high throughout. It consists of 32 ones, start bits 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround bits 10 and the 16 data bits MSB first.
- R4: A read frame uses opcode 10. The output enable is high for frame bits 0 to 45 and low from bit 46 (the turnaround) through bit 63.
- R5: On a read, the line is sampled on the MDC rising edges of frame bits 48 to 63, MSB first. The result appears in read-data bits 15:0 when the go bit has cleared. The register keeps its value until the next read completes.
- R6: Writing control with bit 0 set while enabled and idle makes bit 0 read 1 from the next cycle. It stays 1 until the frame ends, then returns to 0.
- R7: A go request written while the stored enable bit is 0 is ignored: no frame is sent and bit 0 stays 0.
- R8: A go request written while a transaction is running is ignored, and command or data writes made during a transaction do not alter the frame in progress.
- R9: MDC is low out of reset and toggles every MDC_HALF system clocks, giving a 50% duty cycle. The default MDC_HALF of 40 keeps MDC at 2.5 MHz from a 200 MHz clock.
- R10: After reset, all registers read 0, MDC is 0, the output enable is 0 and the data output is 1.
- R11: The data output and the output enable change only on MDC falling edges. They are stable while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte offset of register access |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable (1 = drive) |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the block with MDC_HALF set to 3. A full 64-bit frame then takes 384 system clocks, so dozens of random reads and writes fit in one run alongside the directed ones. The odd half-period also exercises a divider count that is not a power of two. A PHY model in the bench captures every frame on MDC rising edges and returns read data on falling edges. These captured frames are checked bit-for-bit against frames computed from the command word. Measured MDC half-periods and the stability of the output while MDC is high are checked across the whole run.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int BUS_AW       = 12;
    localparam int BUS_DW       = 32;
    localparam int FRAME_BITS   = 64;
    localparam int CNT_W        = $clog2(FRAME_BITS);
    localparam int TA_POS       = 46;
    localparam int DATA_POS     = 48;
    localparam int DATA_W       = 16;

    localparam logic [BUS_AW-1:0] OFF_CMD   = 12'h7E4;
    localparam logic [BUS_AW-1:0] OFF_WDATA = 12'h7E8;
    localparam logic [BUS_AW-1:0] OFF_RDATA = 12'h7EC;
    localparam logic [BUS_AW-1:0] OFF_CTRL  = 12'h7F0;

    localparam int CTRL_GO_BIT = 0;
    localparam int CTRL_EN_BIT = 3;

    typedef struct packed {
        logic       is_read;
        logic [4:0] phy_addr;
        logic [4:0] reg_num;
    } mdio_cmd_t;

    localparam int CMD_W = $bits(mdio_cmd_t);

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input mdio_cmd_t         cmd,
        input logic [DATA_W-1:0] wdata
    );
        logic [1:0] opcode;
        opcode = cmd.is_read ? 2'b10 : 2'b01;
        return {32'hFFFF_FFFF, 2'b01, opcode, cmd.phy_addr, cmd.reg_num,
                2'b10, wdata};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int MDC_HALF = 40
) (
    input  logic clk,
    input  logic rst,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = $clog2(MDC_HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(MDC_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          wrap;

    assign wrap      = (cnt_q == LAST);
    assign rise_tick = wrap && !mdc_q;
    assign fall_tick = wrap && mdc_q;
    assign mdc       = mdc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_RISE_TICK_RAISES_MDC: assert property (@(posedge clk) disable iff (rst)
        rise_tick |=> mdc); // R9
    AST_FALL_TICK_LOWERS_MDC: assert property (@(posedge clk) disable iff (rst)
        fall_tick |=> !mdc); // R9

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    input  logic                 busy,
    input  logic                 rd_load,
    input  logic [DATA_W-1:0]    rd_value,
    output mdio_cmd_t            cmd,
    output logic [DATA_W-1:0]    wdata,
    output logic                 start_req
);
    mdio_cmd_t          cmd_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               en_q;
    logic               go_wr;

    assign go_wr     = bus_wr && (bus_addr == OFF_CTRL) && bus_wdata[CTRL_GO_BIT];
    assign start_req = go_wr && en_q && !busy;
    assign cmd       = cmd_q;
    assign wdata     = wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            en_q    <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == OFF_CMD)   cmd_q   <= mdio_cmd_t'(bus_wdata[CMD_W-1:0]);
            if (bus_wr && bus_addr == OFF_WDATA) wdata_q <= bus_wdata[DATA_W-1:0];
            if (bus_wr && bus_addr == OFF_CTRL)  en_q    <= bus_wdata[CTRL_EN_BIT];
            if (rd_load)                         rdata_q <= rd_value;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CMD:   bus_rdata[CMD_W-1:0]  = cmd_q;
            OFF_WDATA: bus_rdata[DATA_W-1:0] = wdata_q;
            OFF_RDATA: bus_rdata[DATA_W-1:0] = rdata_q;
            OFF_CTRL: begin
                bus_rdata[CTRL_EN_BIT] = en_q;
                bus_rdata[CTRL_GO_BIT] = busy;
            end
            default:   bus_rdata = '0;
        endcase
    end

    AST_GO_IGNORED_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (go_wr && !en_q && !busy) |=> !busy); // R7
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_load) |-> $stable(rdata_q)); // R5

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_load,
    output logic [DATA_W-1:0] rd_value
);
    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SHIFT} eng_state_t;

    eng_state_t              st_q;
    logic [FRAME_BITS-1:0]   frame_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [CNT_W-1:0]        cnt_nxt;
    logic                    is_rd_q;
    logic                    o_q;
    logic                    oe_q;
    logic [DATA_W-1:0]       rx_q;
    logic                    load_q;
    logic                    last_bit;

    assign cnt_nxt  = cnt_q + 1'b1;
    assign last_bit = (cnt_q == CNT_W'(FRAME_BITS - 1));
    assign busy     = (st_q != ST_IDLE);
    assign mdio_o   = o_q;
    assign mdio_oe  = oe_q;
    assign rd_load  = load_q;
    assign rd_value = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            frame_q <= '0;
            cnt_q   <= '0;
            is_rd_q <= 1'b0;
            o_q     <= 1'b1;
            oe_q    <= 1'b0;
            rx_q    <= '0;
            load_q  <= 1'b0;
        end else begin
            load_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        frame_q <= build_frame(cmd, wdata);
                        is_rd_q <= cmd.is_read;
                        st_q    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (fall_tick) begin
                        o_q     <= frame_q[FRAME_BITS-1];
                        oe_q    <= 1'b1;
                        frame_q <= {frame_q[FRAME_BITS-2:0], 1'b1};
                        cnt_q   <= '0;
                        st_q    <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (rise_tick && is_rd_q && cnt_q >= CNT_W'(DATA_POS))
                        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
                    if (fall_tick) begin
                        if (last_bit) begin
                            o_q    <= 1'b1;
                            oe_q   <= 1'b0;
                            load_q <= is_rd_q;
                            st_q   <= ST_IDLE;
                        end else begin
                            o_q     <= frame_q[FRAME_BITS-1];
                            oe_q    <= !(is_rd_q && cnt_nxt >= CNT_W'(TA_POS));
                            frame_q <= {frame_q[FRAME_BITS-2:0], 1'b1};
                            cnt_q   <= cnt_nxt;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SHIFT && is_rd_q && cnt_q >= CNT_W'(TA_POS)) |-> !mdio_oe); // R4
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (busy && !(st_q == ST_SHIFT && fall_tick && last_bit)) |=> busy); // R6
    AST_IDLE_NOT_DRIVING: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe); // R6

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    mdio_cmd_t         cmd;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rd_value;
    logic              start_req;
    logic              busy;
    logic              rd_load;
    logic              rise_tick;
    logic              fall_tick;

    mdio_clkgen #(.MDC_HALF(MDC_HALF)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .rd_load   (rd_load),
        .rd_value  (rd_value),
        .cmd       (cmd),
        .wdata     (wdata),
        .start_req (start_req)
    );

    mdio_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start_req),
        .cmd       (cmd),
        .wdata     (wdata),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_load   (rd_load),
        .rd_value  (rd_value)
    );

    AST_OUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R11
    AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> busy); // R3

endmodule

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
    localparam int HALF = 3;
    localparam logic [11:0] A_CMD = 12'h7E4, A_WD = 12'h7E8, A_RD = 12'h7EC, A_CTRL = 12'h7F0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2.5 clk = !clk;

    mdio_mgmt_master #(.MDC_HALF(HALF)) u_mdio_mgmt_master (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: captures frames, returns read data
    logic [63:0] cap, cap_oe;
    logic [15:0] phy_data = '0;
    int idx = 0;
    bit in_frame = 0;
    int frames = 0;

    always @(posedge mdc) begin
        if (!in_frame && mdio_oe) begin
            in_frame = 1;
            idx = 0;
        end
        if (in_frame) begin
            cap[63-idx]    = mdio_o;
            cap_oe[63-idx] = mdio_oe;
            idx++;
            if (idx == 64) begin
                in_frame = 0;
                frames++;
            end
        end
    end

    always @(negedge mdc) begin
        if (in_frame && idx >= 48 && idx <= 63) mdio_i = phy_data[63-idx];
        else if (in_frame && idx == 47)         mdio_i = 1'b0;
        else                                    mdio_i = 1'b1;
    end

    // MDC run length and output stability monitors
    int mdc_viol = 0, stab_viol = 0, run_len = 0, runs = 0;
    logic prev_mdc = 1'b0, h_o = 1'b1, h_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (mdc != prev_mdc) begin
                if (runs > 0 && run_len != HALF) mdc_viol++;
                runs++;
                run_len = 1;
            end else run_len++;
            if (mdc && prev_mdc && (mdio_o != h_o || mdio_oe != h_oe)) stab_viol++;
            h_o = mdio_o;
            h_oe = mdio_oe;
            prev_mdc = mdc;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
    endfunction

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            bus_read(A_CTRL, v);
            if (!v[0]) break;
        end
    endtask

    task automatic xfer(input bit rd, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        logic [31:0] v;
        logic [63:0] e;
        int f0;
        f0 = frames;
        if (rd) phy_data = d;
        bus_write(A_CMD, {21'd0, rd, phy, rg});
        bus_write(A_WD, rd ? 32'h0000_5555 : {16'hDEAD, d});
        bus_write(A_CTRL, 32'h9);
        bus_read(A_CTRL, v);
        check(v == 32'h9, "R6 busy", {32'd0, v}, 64'h9);
        wait_idle();
        bus_read(A_CTRL, v);
        check(v == 32'h8, "R6 cleared", {32'd0, v}, 64'h8);
        check(frames == f0 + 1, "R3 frame count", 64'(frames), 64'(f0 + 1));
        e = exp_frame(rd, phy, rg, d);
        if (rd) begin
            check(cap[63:18] == e[63:18], "R4 R2 read frame", cap, e);
            check(cap_oe == {{46{1'b1}}, 18'd0}, "R4 oe release", cap_oe, {{46{1'b1}}, 18'd0});
            bus_read(A_RD, v);
            check(v == {16'd0, d}, "R5 read data", {32'd0, v}, {48'd0, d});
        end else begin
            check(cap == e, "R3 R2 write frame", cap, e);
            check(cap_oe == '1, "R3 oe", cap_oe, '1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] last_rd;
        int f0;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        check(mdc == 1'b0 && mdio_oe == 1'b0 && mdio_o == 1'b1, "R10 pins",
              {61'd0, mdc, mdio_oe, mdio_o}, 64'h1);
        bus_read(A_CMD, v);  check(v == 0, "R10 cmd", {32'd0, v}, 0);
        bus_read(A_WD, v);   check(v == 0, "R10 wdata", {32'd0, v}, 0);
        bus_read(A_RD, v);   check(v == 0, "R10 rdata", {32'd0, v}, 0);
        bus_read(A_CTRL, v); check(v == 0, "R10 ctrl", {32'd0, v}, 0);

        // R1 register decode
        bus_write(A_CMD, 32'hFFFF_FFFF);
        bus_read(A_CMD, v);  check(v == 32'h7FF, "R1 cmd mask", {32'd0, v}, 64'h7FF);
        bus_write(A_CMD, 32'h5A5);
        bus_read(A_CMD, v);  check(v == 32'h5A5, "R1 cmd", {32'd0, v}, 64'h5A5);
        bus_write(A_WD, 32'h1234_ABCD);
        bus_read(A_WD, v);   check(v == 32'hABCD, "R1 wdata", {32'd0, v}, 64'hABCD);
        bus_read(12'h100, v); check(v == 0, "R1 unmapped", {32'd0, v}, 0);

        // R7 go ignored while disabled
        f0 = frames;
        bus_write(A_CTRL, 32'h1);
        bus_read(A_CTRL, v); check(v == 0, "R7 status", {32'd0, v}, 0);
        repeat (600) @(posedge clk);
        check(frames == f0 && !mdio_oe, "R7 no frame", 64'(frames), 64'(f0));

        bus_write(A_CTRL, 32'h8);
        bus_read(A_CTRL, v); check(v == 32'h8, "R1 enable readback", {32'd0, v}, 64'h8);

        // directed corners
        xfer(1'b0, 5'd31, 5'd0, 16'hFFFF);
        xfer(1'b0, 5'd0, 5'd31, 16'h0000);
        xfer(1'b1, 5'd1, 5'd1, 16'h1808);
        xfer(1'b1, 5'd31, 5'd31, 16'hFFFF);
        xfer(1'b1, 5'd0, 5'd0, 16'h0000);

        // R8 go and reprogramming while busy
        f0 = frames;
        phy_data = 16'hBEEF;
        bus_write(A_CMD, {21'd0, 1'b1, 5'd5, 5'd2});
        bus_write(A_CTRL, 32'h9);
        repeat (40) @(posedge clk);
        bus_write(A_CMD, {21'd0, 1'b0, 5'd9, 5'd7});
        bus_write(A_WD, 32'h0000_1111);
        bus_write(A_CTRL, 32'h9);
        wait_idle();
        repeat (600) @(posedge clk);
        check(frames == f0 + 1, "R8 single frame", 64'(frames), 64'(f0 + 1));
        check(cap[63:18] == exp_frame(1'b1, 5'd5, 5'd2, 16'h0)[63:18], "R8 frame unchanged",
              cap, exp_frame(1'b1, 5'd5, 5'd2, 16'h0));
        bus_read(A_RD, v); check(v == 32'hBEEF, "R8 read data", {32'd0, v}, 64'hBEEF);

        // R5 read data held across a write transaction
        xfer(1'b0, 5'd3, 5'd4, 16'hA5A5);
        bus_read(A_RD, v); check(v == 32'hBEEF, "R5 held", {32'd0, v}, 64'hBEEF);

        // random mix
        last_rd = 16'hBEEF;
        for (int n = 0; n < 24; n++) begin
            bit rd;
            logic [15:0] d;
            rd = 1'($urandom);
            d = 16'($urandom);
            xfer(rd, 5'($urandom), 5'($urandom), d);
            if (rd) last_rd = d;
            bus_read(A_RD, v);
            check(v == {16'd0, last_rd}, "R5 random rdata", {32'd0, v}, {48'd0, last_rd});
        end

        check(mdc_viol == 0 && runs > 100, "R9 mdc half period", 64'(mdc_viol), 0);
        check(stab_viol == 0, "R11 output stable while mdc high", 64'(stab_viol), 0);

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule